// File: doc/BRIEF.md
# DRAM Single-Bank Command Timing Scheduler

This block takes access requests (read or write, with a row and a column address) through a valid/ready handshake and turns them into the command stream for one SDRAM bank. It keeps track of whether a row is open and which one it is. It then issues activate, precharge, read and write commands, one per cycle at most. Each command waits until the minimum spacing since the previous row command has passed.

The bank is left open after a column access. A later request to the same row goes straight to its column command. A request to a different row first closes the open row and then opens the new one. For every read, a data-valid strobe rises a programmable number of cycles after the read command. This tells the data path when the returned word can be taken.

All four spacings (precharge-to-activate, activate-to-column, activate-to-precharge and read latency) are 4-bit cycle counts. They are taken from input pins while the bank is idle.

Top module: `bank_cmd_sched`

## Requirements
- R1: A read or write command is issued only to the row that is currently open. A request whose row equals the open row is served by its column command alone, with no precharge or activate before it.
- R2: A request to a row other than the open one produces, in order: a precharge, then an activate of the requested row, then the column command.
- R3: An activate issues no sooner than tRP cycles after the preceding precharge. If the bank is already idle, the activate issues in the cycle the request is presented.
- R4: A read or write issues no sooner than tRCD cycles after the activate of its row. When a request is waiting, it issues exactly then.
- R5: A precharge issues no sooner than tRAS cycles after the preceding activate. A waiting miss precharges at the later of that point and the first cycle it is presented.
- R6: rd_valid is high exactly CL cycles after each read command, one pulse per read. Reads on adjacent cycles give adjacent pulses. Writes give no pulse.
- R7: cmd_code is 0 for no command, 1 for activate, 2 for precharge, 3 for read and 4 for write. It is 0 on every cycle without a command. req_ready is high only in the cycle the column command for the presented request is issued.
- R8: A timing value of 0 behaves exactly as a value of 1.
- R9: The timing inputs are captured only while no row is open and no precharge is pending. Changes made while a row is open or being closed have no effect on that row's spacings, nor on the activate that follows its precharge.
- R10: After reset the bank is idle. No command, req_ready or rd_valid is driven. The first request's activate may issue at once, using the timing inputs present in that cycle.
- R11: cmd_row carries the row on an activate. cmd_col carries the column on a read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trp | input | 4 | Precharge-to-activate spacing in cycles |
| cfg_trcd | input | 4 | Activate-to-column spacing in cycles |
| cfg_tras | input | 4 | Activate-to-precharge minimum in cycles |
| cfg_cl | input | 4 | Read-to-data-valid latency in cycles |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 for write, 0 for read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_ready | output | 1 | Request accepted (its column command issues this cycle) |
| cmd_code | output | 3 | Command: 0 none, 1 activate, 2 precharge, 3 read, 4 write |
| cmd_row | output | ROW_W | Row address with an activate, else 0 |
| cmd_col | output | COL_W | Column address with a read or write, else 0 |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
The assertions check the following on every cycle:
- no column command without an open row, and no activate over an open row;
- the precharge-to-activate, activate-to-column and activate-to-precharge minimums, each measured against the value in force when the opening command issued;
- req_ready coinciding with a column command.

Only the bench's scenarios can show the rest:
- that a waiting request is served at the earliest legal cycle rather than later;
- that a miss produces the full close-open-access sequence with the right addresses;
- that each read gets its own strobe exactly CL cycles later;
- that timing inputs changed while a row is open are ignored.

The bench sweeps every combination of small spacings, including zero, and adds a few large and altered-configuration cases.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;

    localparam int TIM_W = 4;
    localparam int MAX_CL = (1 << TIM_W) - 1;

    typedef logic [TIM_W-1:0] tim_t;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVATING,
        ST_ROW_OPEN,
        ST_PRECHARGING
    } bank_st_e;

    typedef struct packed {
        tim_t trp;
        tim_t trcd;
        tim_t tras;
        tim_t cl;
    } timing_t;

    function automatic tim_t clamp_min1(tim_t v);
        return (v == '0) ? tim_t'(1) : v;
    endfunction

    function automatic logic is_column(cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sched_cfg.sv
module sched_cfg
    import bank_sched_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    capture,
    input  timing_t raw,
    output timing_t eff
);
    timing_t raw_c;
    timing_t held;

    always_comb begin
        raw_c.trp  = clamp_min1(raw.trp);
        raw_c.trcd = clamp_min1(raw.trcd);
        raw_c.tras = clamp_min1(raw.tras);
        raw_c.cl   = clamp_min1(raw.cl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '{trp: tim_t'(1), trcd: tim_t'(1), tras: tim_t'(1), cl: tim_t'(1)};
        end else if (capture) begin
            held <= raw_c;
        end
    end

    assign eff = capture ? raw_c : held;
endmodule

// File: rtl/sched_dcount.sv
module sched_dcount #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sched_rdpipe.sv
module sched_rdpipe #(
    parameter int DEPTH = 15,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [IW-1:0] lat,
    output logic          valid_out
);
    logic [DEPTH-1:0] sr;
    logic [DEPTH-1:0] ins;

    always_comb begin
        ins = '0;
        if (push) begin
            ins = DEPTH'(1) << (lat - IW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr <= (sr >> 1) | ins;
        end
    end

    assign valid_out = sr[0];
endmodule

// File: rtl/bank_cmd_sched.sv
module bank_cmd_sched
    import bank_sched_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       cfg_trp,
    input  logic [3:0]       cfg_trcd,
    input  logic [3:0]       cfg_tras,
    input  logic [3:0]       cfg_cl,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    output logic [2:0]       cmd_code,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             rd_valid
);
    localparam int N_CNT = 3;
    localparam int I_RCD = 0;
    localparam int I_RAS = 1;
    localparam int I_RP  = 2;

    bank_st_e         st, st_nx;
    logic [ROW_W-1:0] open_row;
    cmd_e             cmd;
    timing_t          cfg_raw;
    timing_t          cfg_eff;
    logic             open_ok, act_ok, hit;
    logic [N_CNT-1:0] cnt_load, cnt_zero;
    tim_t             cnt_val [N_CNT];

    assign cfg_raw = '{trp: cfg_trp, trcd: cfg_trcd, tras: cfg_tras, cl: cfg_cl};

    sched_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .capture(st == ST_IDLE),
        .raw    (cfg_raw),
        .eff    (cfg_eff)
    );

    assign cnt_load[I_RCD] = (cmd == CMD_ACT);
    assign cnt_load[I_RAS] = (cmd == CMD_ACT);
    assign cnt_load[I_RP]  = (cmd == CMD_PRE);
    assign cnt_val[I_RCD]  = cfg_eff.trcd;
    assign cnt_val[I_RAS]  = cfg_eff.tras;
    assign cnt_val[I_RP]   = cfg_eff.trp;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        sched_dcount #(.W(TIM_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .load    (cnt_load[g]),
            .load_val(cnt_val[g]),
            .zero    (cnt_zero[g])
        );
    end

    assign open_ok = ((st == ST_ACTIVATING) || (st == ST_ROW_OPEN)) && cnt_zero[I_RCD];
    assign act_ok  = (st == ST_IDLE) || ((st == ST_PRECHARGING) && cnt_zero[I_RP]);
    assign hit     = (req_row == open_row);

    always_comb begin
        cmd       = CMD_NOP;
        req_ready = 1'b0;
        if (req_valid) begin
            if (act_ok) begin
                cmd = CMD_ACT;
            end else if (open_ok) begin
                if (hit) begin
                    cmd       = req_write ? CMD_WR : CMD_RD;
                    req_ready = 1'b1;
                end else if (cnt_zero[I_RAS]) begin
                    cmd = CMD_PRE;
                end
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd == CMD_ACT) st_nx = ST_ACTIVATING;
            end
            ST_ACTIVATING: begin
                if (cmd == CMD_PRE)         st_nx = ST_PRECHARGING;
                else if (cnt_zero[I_RCD])   st_nx = ST_ROW_OPEN;
            end
            ST_ROW_OPEN: begin
                if (cmd == CMD_PRE) st_nx = ST_PRECHARGING;
            end
            ST_PRECHARGING: begin
                if (cmd == CMD_ACT)       st_nx = ST_ACTIVATING;
                else if (cnt_zero[I_RP])  st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            open_row <= '0;
        end else begin
            st <= st_nx;
            if (cmd == CMD_ACT) open_row <= req_row;
        end
    end

    sched_rdpipe #(.DEPTH(MAX_CL), .IW(TIM_W)) u_rdpipe (
        .clk      (clk),
        .rst      (rst),
        .push     (cmd == CMD_RD),
        .lat      (cfg_eff.cl),
        .valid_out(rd_valid)
    );

    assign cmd_code = cmd;
    assign cmd_row  = (cmd == CMD_ACT) ? req_row : '0;
    assign cmd_col  = is_column(cmd) ? req_col : '0;
endmodule

// File: rtl/bank_sched_chk.sv
module bank_sched_chk
    import bank_sched_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cmd,
    input logic       ready,
    input tim_t       trcd,
    input tim_t       tras,
    input tim_t       trp
);
    logic [4:0] since_act, since_pre;
    tim_t       rcd_s, ras_s, rp_s;
    logic       ck_open;
    logic       is_col;

    assign is_col = (cmd == 3'd3) || (cmd == 3'd4);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 5'd31;
            since_pre <= 5'd31;
            rcd_s     <= tim_t'(1);
            ras_s     <= tim_t'(1);
            rp_s      <= tim_t'(1);
            ck_open   <= 1'b0;
        end else begin
            if (cmd == 3'd1) begin
                since_act <= 5'd1;
                rcd_s     <= trcd;
                ras_s     <= tras;
                ck_open   <= 1'b1;
            end else if (since_act != 5'd31) begin
                since_act <= since_act + 5'd1;
            end
            if (cmd == 3'd2) begin
                since_pre <= 5'd1;
                rp_s      <= trp;
                ck_open   <= 1'b0;
            end else if (since_pre != 5'd31) begin
                since_pre <= since_pre + 5'd1;
            end
        end
    end

    assert_col_needs_open_R1: assert property (@(posedge clk) disable iff (rst)
        is_col |-> ck_open);
    assert_act_needs_closed_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1) |-> !ck_open);
    assert_rp_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1) |-> (since_pre >= {1'b0, rp_s}));
    assert_rcd_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (since_act >= {1'b0, rcd_s}));
    assert_ras_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2) |-> (since_act >= {1'b0, ras_s}));
    assert_ready_on_col_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> is_col);
    assert_col_has_ready_R7: assert property (@(posedge clk) disable iff (rst)
        is_col |-> ready);
    assert_legal_code_R7: assert property (@(posedge clk) disable iff (rst)
        cmd <= 3'd4);
endmodule

bind bank_cmd_sched bank_sched_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .cmd  (cmd_code),
    .ready(req_ready),
    .trcd (cfg_eff.trcd),
    .tras (cfg_eff.tras),
    .trp  (cfg_eff.trp)
);

// File: tb/tb_bank_cmd_sched.sv
module tb_bank_cmd_sched;
    localparam int ROW_W = 13;
    localparam int COL_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [3:0]       cfg_trp = '0, cfg_trcd = '0, cfg_tras = '0, cfg_cl = '0;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_ready, rd_valid;
    logic [2:0]       cmd_code;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    bank_cmd_sched #(.ROW_W(ROW_W), .COL_W(COL_W)) dut (
        .clk(clk), .rst(rst),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_cl(cfg_cl),
        .req_valid(req_valid), .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .rd_valid(rd_valid)
    );

    int n_cmd, n_rv, n_rdy;
    int c_code [32];
    int c_cyc  [32];
    int c_addr [32];
    int rv_cyc [32];
    int rdy_cyc[32];

    always @(negedge clk) begin
        if (rst) begin
            n_cmd = 0; n_rv = 0; n_rdy = 0;
        end else begin
            if (cmd_code != 3'd0 && n_cmd < 32) begin
                c_code[n_cmd] = int'(cmd_code);
                c_cyc[n_cmd]  = cyc;
                c_addr[n_cmd] = (cmd_code == 3'd1) ? int'(cmd_row) : int'(cmd_col);
                n_cmd++;
            end
            if (rd_valid && n_rv < 32) begin rv_cyc[n_rv] = cyc; n_rv++; end
            if (req_ready && n_rdy < 32) begin rdy_cyc[n_rdy] = cyc; n_rdy++; end
        end
    end

    int vectors = 0, errors = 0;
    bit done = 0;

    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_req(bit wr, int row, int col);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr;
        req_row = ROW_W'(row); req_col = COL_W'(col);
        do @(negedge clk); while (!req_ready);
    endtask

    function automatic int e1(int v); return (v == 0) ? 1 : v; endfunction
    function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

    task automatic scenario(int rcd, int rp, int ras, int cl, bit scramble, int k);
        int ercd, erp, eras, ecl, s1, ra, rb;
        int e_code[10], e_cyc[10], e_addr[10], cols[5];
        string tag[10];
        string cfgs;
        ercd = e1(rcd); erp = e1(rp); eras = e1(ras); ecl = e1(cl);
        cfgs = $sformatf("[rcd%0d rp%0d ras%0d cl%0d s%0d]", rcd, rp, ras, cl, scramble);
        ra = (k * 37 + 5) % 8192; rb = ra ^ 1;
        for (int i = 0; i < 5; i++) cols[i] = (k * 11 + i * 97 + 3) % 1024;
        rst = 1'b1; req_valid = 1'b0;
        cfg_trcd = 4'(rcd); cfg_trp = 4'(rp); cfg_tras = 4'(ras); cfg_cl = 4'(cl);
        repeat (2) @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk({"R10 idle cmd after reset ", cfgs}, int'(cmd_code), 0);
        chk({"R10 ready after reset ", cfgs}, int'(req_ready), 0);
        chk({"R10 rd_valid after reset ", cfgs}, int'(rd_valid), 0);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0;
        req_row = ROW_W'(ra); req_col = COL_W'(cols[0]);
        s1 = cyc;
        do @(negedge clk); while (!req_ready);
        if (scramble) begin
            cfg_trcd = 4'(rcd) ^ 4'hA; cfg_trp = 4'(rp) ^ 4'h5;
            cfg_tras = 4'(ras) ^ 4'hC; cfg_cl = 4'(cl) ^ 4'h6;
        end
        do_req(1'b1, rb, cols[1]);
        do_req(1'b0, rb, cols[2]);
        do_req(1'b0, rb, cols[3]);
        do_req(1'b0, ra, cols[4]);
        @(posedge clk); #1 req_valid = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);

        e_code[0] = 1; e_cyc[0] = s1;                       e_addr[0] = ra;      tag[0] = "R10 first activate";
        e_code[1] = 3; e_cyc[1] = e_cyc[0] + ercd;          e_addr[1] = cols[0]; tag[1] = "R4 read after activate";
        e_code[2] = 2; e_cyc[2] = mx(e_cyc[1] + 1, e_cyc[0] + eras); e_addr[2] = 0; tag[2] = "R5 precharge spacing";
        e_code[3] = 1; e_cyc[3] = e_cyc[2] + erp;           e_addr[3] = rb;      tag[3] = "R3 activate after precharge";
        e_code[4] = 4; e_cyc[4] = e_cyc[3] + ercd;          e_addr[4] = cols[1]; tag[4] = "R4 write after activate";
        e_code[5] = 3; e_cyc[5] = e_cyc[4] + 1;             e_addr[5] = cols[2]; tag[5] = "R1 hit read";
        e_code[6] = 3; e_cyc[6] = e_cyc[5] + 1;             e_addr[6] = cols[3]; tag[6] = "R1 back-to-back hit read";
        e_code[7] = 2; e_cyc[7] = mx(e_cyc[6] + 1, e_cyc[3] + eras); e_addr[7] = 0; tag[7] = "R5 second precharge";
        e_code[8] = 1; e_cyc[8] = e_cyc[7] + erp;           e_addr[8] = ra;      tag[8] = "R3 second activate";
        e_code[9] = 3; e_cyc[9] = e_cyc[8] + ercd;          e_addr[9] = cols[4]; tag[9] = "R4 read after miss";

        chk({"R2 command count ", cfgs}, n_cmd, 10);
        for (int i = 0; i < 10; i++) begin
            if (i < n_cmd) begin
                chk($sformatf("R2 R7 code of cmd %0d %s", i, cfgs), c_code[i], e_code[i]);
                chk($sformatf("%s cycle %s", tag[i], cfgs), c_cyc[i], e_cyc[i]);
                chk($sformatf("R11 address of cmd %0d %s", i, cfgs), c_addr[i], e_addr[i]);
            end
        end
        chk({"R6 rd_valid pulse count ", cfgs}, n_rv, 4);
        if (n_rv == 4) begin
            chk({"R6 valid of first read ", cfgs}, rv_cyc[0], e_cyc[1] + ecl);
            chk({"R6 valid of hit read ", cfgs}, rv_cyc[1], e_cyc[5] + ecl);
            chk({"R6 valid of adjacent read ", cfgs}, rv_cyc[2], e_cyc[6] + ecl);
            chk({"R6 valid of last read ", cfgs}, rv_cyc[3], e_cyc[9] + ecl);
        end
        chk({"R7 ready count ", cfgs}, n_rdy, 5);
        if (n_rdy == 5) begin
            chk({"R7 ready on read ", cfgs}, rdy_cyc[0], e_cyc[1]);
            chk({"R7 ready on write ", cfgs}, rdy_cyc[1], e_cyc[4]);
            chk({"R7 ready on last read ", cfgs}, rdy_cyc[4], e_cyc[9]);
        end
        if (rcd == 0 && n_cmd > 1) chk({"R8 zero rcd acts as one ", cfgs}, c_cyc[1] - c_cyc[0], 1);
        if (cl == 0 && n_rv > 0 && n_cmd > 1) chk({"R8 zero cl acts as one ", cfgs}, rv_cyc[0] - c_cyc[1], 1);
        if (scramble && n_cmd > 8) begin
            chk({"R9 precharge-activate spacing kept ", cfgs}, c_cyc[8] - c_cyc[7], erp);
            chk({"R9 activate-column spacing kept ", cfgs}, c_cyc[9] - c_cyc[8], ercd);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            vectors++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int k;
        k = 0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++) begin
                        scenario(a, b, c, d, 1'b0, k);
                        k++;
                    end
        scenario(15, 15, 15, 15, 1'b0, k + 1);
        scenario(2, 3, 9, 15, 1'b0, k + 2);
        scenario(5, 7, 9, 11, 1'b1, k + 3);
        scenario(2, 3, 6, 4, 1'b1, k + 4);
        scenario(0, 0, 0, 0, 1'b1, k + 5);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule